// File: doc/BRIEF.md
# Buck Output Soft-Start and Fault Latch Supervisor

This block watches one switching output of a step-down regulator from power-on onward. It measures the start-up interval by counting oscillator ticks. It compares a sampled output-voltage code against a nominal code, and from that comparison it finds under-voltage, over-voltage and start-up timeout faults. When a fault occurs, the block latches it. From then on the high-side gate enable is held low and the low-side gate enable is held high. Only a power-on reset clears the latch.

While no fault is latched, two current-sense flags mask the gate enables within the same cycle. The positive-limit flag removes the high-side enable and the negative-limit flag removes the low-side enable. The PWM stage combines these enables with its own drive.

There is no streaming interface. The block samples the output code and the nominal code on every clock, and every pin is a plain level. No handshake or back-pressure applies.

Top module: `buck_ss_supervisor`

## Requirements
- R1: After reset the block is in soft-start: `running` is 0, `fault_code` is 0 (none), and the gate enables follow only the current-limit flags.
- R2: The thresholds are rounded down: the under-voltage limit is floor(7·N/10), the over-voltage limit is floor(3·N/2) and the start-good level is floor(99·N/100), where N is `vnom_code`. Under-voltage needs the output to be strictly below its limit, over-voltage needs it strictly above its limit, and start-good needs it at or above its level.
- R3: `running` rises only after a clock on which `osc_tick` is 1 while in soft-start, the output is at or above the start-good level, and there is no over-voltage.
- R4: If the WINDOW_TICKS-th tick of soft-start finds the output below the start-good level, `fault_code` becomes 3 (timeout) after that edge.
- R5: Under-voltage is ignored during soft-start. In the running state it is checked first on the tick after entry, and on every clock after that tick. A detection sets `fault_code` to 1.
- R6: Over-voltage is checked on every clock in soft-start and in running, and sets `fault_code` to 2. On the same edge it takes precedence over start-good, timeout and under-voltage.
- R7: While a fault is latched, `hs_en` is 0, `ls_en` is 1 and `running` is 0, whatever the current-limit flags are.
- R8: A latched fault holds its state and its code through any later tick, output code or nominal code, until `rst_n` is asserted.
- R9: Outside a fault, `ilim_pos`=1 drives `hs_en` to 0 in the same cycle and `ilim_neg`=1 drives `ls_en` to 0 in the same cycle. Otherwise each enable is 1.
- R10: `fault_code` reports the first fault that latched, with the encoding 0 none, 1 under-voltage, 2 over-voltage, 3 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| vout_code | input | CODE_W | Sampled output-voltage code |
| vnom_code | input | CODE_W | Nominal output code |
| ilim_pos | input | 1 | Positive current-limit comparator flag |
| ilim_neg | input | 1 | Negative current-limit comparator flag |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault_code | output | 2 | Latched fault code |
| running | output | 1 | Soft-start finished, no fault |

## Verification
The bench builds the block with CODE_W=10 and WINDOW_TICKS=32, and keeps the default ratios. A 32-tick window lets timeouts happen within a few hundred cycles. With the counter that short, both the last-tick edge and the arming of the under-voltage check occur in many random episodes. A nominal code of 101 makes every floor rounding visible at the threshold boundaries.

// File: rtl/ss_sup_pkg.sv
package ss_sup_pkg;
  typedef enum logic [1:0] {
    ST_SOFT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } sup_state_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_UV      = 2'd1,
    FLT_OV      = 2'd2,
    FLT_TIMEOUT = 2'd3
  } fault_e;
endpackage

// File: rtl/ss_ratio_thresh.sv
// Threshold = floor(nom * MUL / DIV), widened by one bit for ratios above 1.
module ss_ratio_thresh #(
  parameter int CODE_W = 10,
  parameter int MUL    = 7,
  parameter int DIV    = 10
) (
  input  logic [CODE_W-1:0] nom_i,
  output logic [CODE_W:0]   thr_o
);
  localparam int TW = CODE_W + 1;
  localparam int PW = CODE_W + $clog2(MUL + 1) + 1;

  logic [PW-1:0] prod;

  assign prod  = PW'(nom_i) * PW'(MUL);
  assign thr_o = TW'(prod / PW'(DIV));
endmodule

// File: rtl/ss_tick_window.sv
// Counts soft-start ticks; last_o marks the final tick of the window.
module ss_tick_window #(
  parameter int TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic last_o
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST);

  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ss_fault_fsm.sv
module ss_fault_fsm
  import ss_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       uv_hit_i,
  input  logic       ov_hit_i,
  input  logic       ok_hit_i,
  input  logic       win_last_i,
  output sup_state_e state_o,
  output fault_e     fault_o,
  output logic       win_adv_o
);
  sup_state_e state_q, state_d;
  fault_e     fault_q, fault_d;
  logic       arm_q, arm_d;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    arm_d   = arm_q;
    unique case (state_q)
      ST_SOFT: begin
        if (ov_hit_i) begin
          state_d = ST_LATCH;
          fault_d = FLT_OV;
        end else if (tick_i) begin
          if (ok_hit_i) begin
            state_d = ST_RUN;
            arm_d   = 1'b0;
          end else if (win_last_i) begin
            state_d = ST_LATCH;
            fault_d = FLT_TIMEOUT;
          end
        end
      end
      ST_RUN: begin
        if (ov_hit_i) begin
          state_d = ST_LATCH;
          fault_d = FLT_OV;
        end else if (uv_hit_i && (arm_q || tick_i)) begin
          state_d = ST_LATCH;
          fault_d = FLT_UV;
        end else if (tick_i) begin
          arm_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_LATCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SOFT;
      fault_q <= FLT_NONE;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      arm_q   <= arm_d;
    end
  end

  assign state_o   = state_q;
  assign fault_o   = fault_q;
  assign win_adv_o = (state_q == ST_SOFT) && tick_i;

  // R8
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCH) |=> (state_q == ST_LATCH) && $stable(fault_q));

  // R3
  run_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOFT && !tick_i) |=> (state_q != ST_RUN));

  // R4
  timeout_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOFT && tick_i && win_last_i && !ok_hit_i && !ov_hit_i)
      |=> (fault_q == FLT_TIMEOUT));

  // R5
  uv_masked_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOFT) |=> (fault_q != FLT_UV));
endmodule

// File: rtl/ss_gate_mask.sv
module ss_gate_mask (
  input  logic latched_i,
  input  logic ilim_pos_i,
  input  logic ilim_neg_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  always_comb begin
    if (latched_i) begin
      hs_en_o = 1'b0;
      ls_en_o = 1'b1;
    end else begin
      hs_en_o = ~ilim_pos_i;
      ls_en_o = ~ilim_neg_i;
    end
  end

  // R9
  always_comb begin
    if (!latched_i) begin
      neg_mask_chk: assert (!(ilim_neg_i && ls_en_o));
    end
  end
endmodule

// File: rtl/buck_ss_supervisor.sv
module buck_ss_supervisor
  import ss_sup_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int WINDOW_TICKS = 4096,
  parameter int UV_MUL       = 7,
  parameter int UV_DIV       = 10,
  parameter int OV_MUL       = 3,
  parameter int OV_DIV       = 2,
  parameter int OK_MUL       = 99,
  parameter int OK_DIV       = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vnom_code,
  input  logic              ilim_pos,
  input  logic              ilim_neg,
  output logic              hs_en,
  output logic              ls_en,
  output logic [1:0]        fault_code,
  output logic              running
);
  localparam int TW    = CODE_W + 1;
  localparam int N_THR = 3;
  localparam int IDX_UV = 0;
  localparam int IDX_OV = 1;
  localparam int IDX_OK = 2;
  localparam int RMUL [N_THR] = '{UV_MUL, OV_MUL, OK_MUL};
  localparam int RDIV [N_THR] = '{UV_DIV, OV_DIV, OK_DIV};

  logic [TW-1:0] thr [N_THR];
  logic [TW-1:0] vout_w;
  logic          uv_hit, ov_hit, ok_hit;
  logic          win_last, win_adv;
  sup_state_e    state;
  fault_e        fault;

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    ss_ratio_thresh #(
      .CODE_W (CODE_W),
      .MUL    (RMUL[g]),
      .DIV    (RDIV[g])
    ) u_thr (
      .nom_i (vnom_code),
      .thr_o (thr[g])
    );
  end

  assign vout_w = {1'b0, vout_code};
  assign uv_hit = (vout_w <  thr[IDX_UV]);
  assign ov_hit = (vout_w >  thr[IDX_OV]);
  assign ok_hit = (vout_w >= thr[IDX_OK]);

  ss_tick_window #(.TICKS(WINDOW_TICKS)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (win_adv),
    .last_o (win_last)
  );

  ss_fault_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (osc_tick),
    .uv_hit_i   (uv_hit),
    .ov_hit_i   (ov_hit),
    .ok_hit_i   (ok_hit),
    .win_last_i (win_last),
    .state_o    (state),
    .fault_o    (fault),
    .win_adv_o  (win_adv)
  );

  ss_gate_mask u_gate (
    .latched_i  (state == ST_LATCH),
    .ilim_pos_i (ilim_pos),
    .ilim_neg_i (ilim_neg),
    .hs_en_o    (hs_en),
    .ls_en_o    (ls_en)
  );

  assign fault_code = fault;
  assign running    = (state == ST_RUN);

  // R7
  fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0) |-> (!hs_en && ls_en && !running));

  // R9
  pos_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd0 && ilim_pos) |-> !hs_en);

  // R6
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd0 && ov_hit) |=> (fault_code == 2'd2));
endmodule

// File: tb/buck_ss_supervisor_tb_top.sv
module buck_ss_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 10;
  localparam int WIN        = 32;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              osc_tick = 1'b0;
  logic [CODE_W-1:0] vout_code = '0;
  logic [CODE_W-1:0] vnom_code = '0;
  logic              ilim_pos = 1'b0;
  logic              ilim_neg = 1'b0;
  logic              hs_en, ls_en, running;
  logic [1:0]        fault_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model state: 0 soft, 1 run, 2 latched
  int m_st, m_cnt, m_fc;
  bit m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_ss_supervisor #(.CODE_W(CODE_W), .WINDOW_TICKS(WIN)) dut_i (
    .clk, .rst_n, .osc_tick, .vout_code, .vnom_code,
    .ilim_pos, .ilim_neg, .hs_en, .ls_en, .fault_code, .running
  );

  function automatic int f_uv(int n); return (n * 7) / 10;   endfunction
  function automatic int f_ov(int n); return (n * 3) / 2;    endfunction
  function automatic int f_ok(int n); return (n * 99) / 100; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_fc <= 0; m_arm <= 1'b0;
    end else begin
      int v, n;
      v = int'(vout_code);
      n = int'(vnom_code);
      if (m_st == 0) begin
        if (v > f_ov(n)) begin
          m_st <= 2; m_fc <= 2;
        end else if (osc_tick) begin
          if (v >= f_ok(n)) begin
            m_st <= 1; m_arm <= 1'b0;
          end else if (m_cnt == WIN - 1) begin
            m_st <= 2; m_fc <= 3;
          end else begin
            m_cnt <= m_cnt + 1;
          end
        end
      end else if (m_st == 1) begin
        if (v > f_ov(n)) begin
          m_st <= 2; m_fc <= 2;
        end else if (v < f_uv(n) && (m_arm || osc_tick)) begin
          m_st <= 2; m_fc <= 1;
        end else if (osc_tick) begin
          m_arm <= 1'b1;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R10 fault_code", int'(fault_code), m_fc);
    check("R3 running", int'(running), (m_st == 1) ? 1 : 0);
    if (m_st == 2) begin
      check("R7 hs_en", int'(hs_en), 0);
      check("R7 ls_en", int'(ls_en), 1);
    end else begin
      check("R9 hs_en", int'(hs_en), ilim_pos ? 0 : 1);
      check("R9 ls_en", int'(ls_en), ilim_neg ? 0 : 1);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic tick_once();
    osc_tick = 1'b1;
    step();
    osc_tick = 1'b0;
    step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    osc_tick = 1'b0; ilim_pos = 1'b0; ilim_neg = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));

    // R1 reset state
    vnom_code = 10'd100; vout_code = 10'd0;
    do_reset();
    check("R1 fault_code", int'(fault_code), 0);
    check("R1 running", int'(running), 0);
    check("R1 hs_en", int'(hs_en), 1);
    check("R1 ls_en", int'(ls_en), 1);

    // R9 masking in soft-start
    ilim_pos = 1'b1; step();
    check("R9 pos mask", int'(hs_en), 0);
    ilim_pos = 1'b0; ilim_neg = 1'b1; step();
    check("R9 neg mask", int'(ls_en), 0);
    ilim_neg = 1'b0;

    // R3 start-good at 99 for nominal 100, not at 98
    vout_code = 10'd98;
    repeat (3) tick_once();
    check("R3 below level", int'(running), 0);
    vout_code = 10'd99; tick_once();
    check("R3 enter run", int'(running), 1);

    // R5 unarmed UV ignored, R2 70 is not under-voltage
    vout_code = 10'd69; step(); step();
    check("R5 unarmed", int'(fault_code), 0);
    vout_code = 10'd70; tick_once();
    check("R2 uv boundary", int'(fault_code), 0);
    vout_code = 10'd69; step();
    check("R5 uv latch", int'(fault_code), 1);

    // R8 hold under later stimulus, R7 forced gates
    vout_code = 10'd300; ilim_pos = 1'b1; ilim_neg = 1'b1;
    repeat (4) tick_once();
    check("R8 held code", int'(fault_code), 1);
    check("R7 ls forced", int'(ls_en), 1);
    check("R7 hs forced", int'(hs_en), 0);

    // R4 timeout, R5 no UV in soft-start
    vnom_code = 10'd100; vout_code = 10'd50;
    do_reset();
    repeat (WIN - 1) tick_once();
    check("R5 soft no uv", int'(fault_code), 0);
    tick_once();
    check("R4 timeout", int'(fault_code), 3);

    // R2 rounding for nominal 101: ov limit 151
    vnom_code = 10'd101; vout_code = 10'd151;
    do_reset();
    step();
    check("R2 ov boundary", int'(fault_code), 0);
    vout_code = 10'd152; step();
    check("R6 ov latch", int'(fault_code), 2);

    // R6 precedence over start-good on the same tick
    vnom_code = 10'd100; vout_code = 10'd0;
    do_reset();
    vout_code = 10'd151; tick_once();
    check("R6 priority code", int'(fault_code), 2);
    check("R6 priority run", int'(running), 0);

    // R6 in running state
    vout_code = 10'd100;
    do_reset();
    tick_once();
    vout_code = 10'd160; step();
    check("R6 ov in run", int'(fault_code), 2);

    // random episodes around the thresholds
    for (int ep = 0; ep < 30; ep++) begin
      int n;
      n = 40 + int'($urandom % 660);
      vnom_code = CODE_W'(n);
      vout_code = '0;
      do_reset();
      for (int c = 0; c < 400; c++) begin
        int v, k;
        k = int'($urandom % 8);
        case (k)
          0: v = f_uv(n) - 1 + int'($urandom % 3);
          1: v = f_ok(n) - 1 + int'($urandom % 3);
          2: v = f_ov(n) - 1 + int'($urandom % 3);
          3: v = int'($urandom % 1024);
          default: v = n - 2 + int'($urandom % 5);
        endcase
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        if (($urandom % 6) == 0) vout_code = CODE_W'(v);
        osc_tick = (($urandom % 4) == 0);
        ilim_pos = (($urandom % 8) == 0);
        ilim_neg = (($urandom % 8) == 0);
        step();
      end
    end

    finish_run();
  end
endmodule